// File: doc/BRIEF.md
# Late-Write Synchronous Burst SRAM

A synthesizable, scaled-down model of a synchronous static RAM that lets every clock carry a new command, including a direct switch from read to write and back. All control, address and data inputs are sampled on the rising clock edge. A write supplies its address and byte enables in one cycle and its data one edge later in flow-through mode, or two edges later in pipelined mode. The write is committed to the array on the edge that brings its data.

A read returns data in the cycle after its command in flow-through mode. In pipelined mode it returns data one cycle later, through an output register. A pipelined read of a word whose write data arrives on the same edge that loads the output register receives that data, byte-merged over the array contents. A two-bit burst sequencer steps through a four-word block in either wrapping-increment or XOR order. An output enable and a sleep input gate the read data asynchronously.

The block is meant for memory-controller testbenches and FPGA emulation. It uses a small parameterised array in place of a full-depth device.

Top module: `lw_burst_sram`

## Requirements
- R1: A load command (adv_i=0) selects the device only when ce1_ni=0, ce2_i=1 and ce3_ni=0. Any other chip-enable combination is a deselect, produces no read data and ends any burst.
- R2: With pipe_mode_i=0, a read command at edge N drives dq_oe_o=1 and the addressed word on data_o in the cycle after edge N.
- R3: With pipe_mode_i=1, a read command at edge N drives its data in the cycle after edge N+1.
- R4: A write command at edge N takes its data from data_i at edge N+1 when pipe_mode_i=0, or at edge N+2 when pipe_mode_i=1. Write cycles never drive dq_oe_o.
- R5: bw_ni is sampled with the write address and is active low. bw_ni[0] guards bits 8:0 and bw_ni[1] guards bits 17:9. A lane with its enable high keeps its old contents.
- R6: Read, write and read commands may follow one another on consecutive edges with no idle cycle. Every read returns the value left by all writes whose data edge is no later than the edge on which that read's data is captured, byte-merged per lane.
- R7: With burst_ilv_i=0, beat n of a burst that starts at address A accesses {A[hi:2], (A[1:0]+n) mod 4}.
- R8: With burst_ilv_i=1, beat n accesses {A[hi:2], A[1:0] XOR n}.
- R9: An advance command (adv_i=1) continues the current burst in its original direction. It ignores the chip enables and we_ni, and still samples bw_ni. An advance with no burst in progress, or after the fourth beat, is a deselect.
- R10: While oe_ni=1, dq_oe_o=0 and data_o=0, independent of the clock.
- R11: While sleep_i=1, dq_oe_o=0 and data_o=0, commands are ignored and any burst ends. Writes already issued still take their data and commit.
- R12: While rst_ni=0, dq_oe_o=0 and data_o=0, and no burst or write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_mode_i | input | 1 | 1 = pipelined with double late write, 0 = flow-through with single late write |
| burst_ilv_i | input | 1 | 1 = XOR burst order, 0 = wrapping-increment order |
| sleep_i | input | 1 | Power-down request, asynchronous on the outputs |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| adv_i | input | 1 | 1 = advance the burst, 0 = load a new address |
| we_ni | input | 1 | 0 = write, 1 = read (load cycles only) |
| bw_ni | input | LANES | Per-lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| data_i | input | LANES*BYTE_W | Late write data |
| data_o | output | LANES*BYTE_W | Read data, zero when not driven |
| dq_oe_o | output | 1 | Read data valid and drivers on |

## Verification
The assertions take for granted that pipe_mode_i only changes while rst_ni is low and that burst_ilv_i is steady for the whole of a burst. They also take every input to be synchronous except oe_ni and sleep_i. The bench changes the mode only inside its reset task, changes the burst order only between bursts, and drives all inputs at the falling edge.

Each cycle, the bench compares both outputs against a model array. The model commits writes on their data edge and resolves reads on their capture edge, with both edges derived from the mode. The stimulus sweeps every address, every byte-enable pattern, every chip-enable combination and every burst start in both orders.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low address bits of burst beat n
  function automatic logic [1:0] beat_lo(logic [1:0] start, logic [1:0] n, logic ilv);
    return ilv ? (start ^ n) : (start + n);
  endfunction
endpackage

// File: rtl/lw_sram_burst.sv
module lw_sram_burst
  import lw_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic             adv_i,
  input  logic             sel_i,
  input  logic             we_ni,
  input  logic             ilv_i,
  input  logic [LANES-1:0] bw_ni,
  input  logic [AW-1:0]    addr_i,
  output op_e              op_o,
  output logic [AW-1:0]    acc_addr_o,
  output logic [LANES-1:0] acc_bw_o
);
  localparam logic [1:0] LAST_BEAT = 2'd3;

  logic          act_q, wr_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic          more;

  assign more = act_q && (cnt_q != LAST_BEAT);

  always_comb begin
    op_o       = OP_IDLE;
    acc_addr_o = addr_i;
    if (!sleep_i) begin
      if (!adv_i) begin
        if (sel_i) op_o = we_ni ? OP_RD : OP_WR;
      end else if (more) begin
        op_o       = wr_q ? OP_WR : OP_RD;
        acc_addr_o = {base_q[AW-1:2], beat_lo(base_q[1:0], cnt_q + 2'd1, ilv_i)};
      end
    end
  end

  assign acc_bw_o = (op_o == OP_WR) ? ~bw_ni : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (op_o == OP_IDLE) begin
      act_q <= 1'b0;
    end else if (!adv_i) begin
      act_q  <= 1'b1;
      wr_q   <= !we_ni;
      base_q <= addr_i;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 2'd1;
    end
  end
endmodule

// File: rtl/lw_sram_wpipe.sv
module lw_sram_wpipe #(
  parameter int AW      = 6,
  parameter int LANES   = 2,
  parameter int LAG_MAX = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pipe_i,
  input  logic             push_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] bw_i,
  output logic             cm_v_o,
  output logic [AW-1:0]    cm_a_o,
  output logic [LANES-1:0] cm_bw_o
);
  localparam int FT_IDX = 0;
  localparam int PL_IDX = LAG_MAX - 1;

  logic [LAG_MAX-1:0] v_q;
  logic [AW-1:0]      a_q [LAG_MAX];
  logic [LANES-1:0]   b_q [LAG_MAX];

  for (genvar i = 0; i < LAG_MAX; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[i] <= 1'b0;
          a_q[i] <= '0;
          b_q[i] <= '0;
        end else begin
          v_q[i] <= push_i;
          a_q[i] <= addr_i;
          b_q[i] <= bw_i;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[i] <= 1'b0;
          a_q[i] <= '0;
          b_q[i] <= '0;
        end else begin
          v_q[i] <= v_q[i-1];
          a_q[i] <= a_q[i-1];
          b_q[i] <= b_q[i-1];
        end
      end
    end
  end

  // the stage whose data is on data_i this cycle
  assign cm_v_o  = pipe_i ? v_q[PL_IDX] : v_q[FT_IDX];
  assign cm_a_o  = pipe_i ? a_q[PL_IDX] : a_q[FT_IDX];
  assign cm_bw_o = pipe_i ? b_q[PL_IDX] : b_q[FT_IDX];
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int BW    = 9
) (
  input  logic                clk_i,
  input  logic                we_i,
  input  logic [AW-1:0]       wa_i,
  input  logic [LANES-1:0]    wbw_i,
  input  logic [LANES*BW-1:0] wd_i,
  input  logic [AW-1:0]       ra_i,
  output logic [LANES*BW-1:0] rd_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BW-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wbw_i[l]) lane_mem[wa_i] <= wd_i[l*BW +: BW];
    end
    assign rd_o[l*BW +: BW] = lane_mem[ra_i];
  end
endmodule

// File: rtl/lw_sram_rdpath.sv
module lw_sram_rdpath #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int BW    = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pipe_i,
  input  logic                rd_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [LANES*BW-1:0] arr_i,
  input  logic                cm_v_i,
  input  logic [AW-1:0]       cm_a_i,
  input  logic [LANES-1:0]    cm_bw_i,
  input  logic [LANES*BW-1:0] wd_i,
  output logic [AW-1:0]       ra_o,
  output logic                vld_o,
  output logic [LANES*BW-1:0] dat_o
);
  localparam int DW = LANES * BW;

  logic          rv_q, ov_q;
  logic [AW-1:0] ra_q;
  logic [DW-1:0] od_q, fwd;
  logic          hit;

  assign hit = cm_v_i && (cm_a_i == ra_q);

  // merge write data landing on this edge into the output register
  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign fwd[l*BW +: BW] = (hit && cm_bw_i[l]) ? wd_i[l*BW +: BW] : arr_i[l*BW +: BW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q <= 1'b0;
      ra_q <= '0;
      ov_q <= 1'b0;
      od_q <= '0;
    end else begin
      rv_q <= rd_i;
      ra_q <= addr_i;
      ov_q <= rv_q;
      od_q <= fwd;
    end
  end

  assign ra_o  = ra_q;
  assign vld_o = pipe_i ? ov_q : rv_q;
  assign dat_o = pipe_i ? od_q : arr_i;
endmodule

// File: rtl/lw_burst_sram.sv
module lw_burst_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pipe_mode_i,
  input  logic                    burst_ilv_i,
  input  logic                    sleep_i,
  input  logic                    oe_ni,
  input  logic                    ce1_ni,
  input  logic                    ce2_i,
  input  logic                    ce3_ni,
  input  logic                    adv_i,
  input  logic                    we_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*BYTE_W-1:0] data_i,
  output logic [LANES*BYTE_W-1:0] data_o,
  output logic                    dq_oe_o
);
  localparam int DATA_W  = LANES * BYTE_W;
  localparam int LAG_MAX = 2;

  logic              sel;
  op_e               op;
  logic [ADDR_W-1:0] acc_a, cm_a, ra;
  logic [LANES-1:0]  acc_bw, cm_bw;
  logic              cm_v, vld;
  logic [DATA_W-1:0] arr_d, dat;

  assign sel = !ce1_ni && ce2_i && !ce3_ni;

  lw_sram_burst #(.AW(ADDR_W), .LANES(LANES)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_i    (sleep_i),
    .adv_i      (adv_i),
    .sel_i      (sel),
    .we_ni      (we_ni),
    .ilv_i      (burst_ilv_i),
    .bw_ni      (bw_ni),
    .addr_i     (addr_i),
    .op_o       (op),
    .acc_addr_o (acc_a),
    .acc_bw_o   (acc_bw)
  );

  lw_sram_wpipe #(.AW(ADDR_W), .LANES(LANES), .LAG_MAX(LAG_MAX)) u_wpipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pipe_i  (pipe_mode_i),
    .push_i  (op == OP_WR),
    .addr_i  (acc_a),
    .bw_i    (acc_bw),
    .cm_v_o  (cm_v),
    .cm_a_o  (cm_a),
    .cm_bw_o (cm_bw)
  );

  lw_sram_array #(.AW(ADDR_W), .LANES(LANES), .BW(BYTE_W)) u_array (
    .clk_i (clk_i),
    .we_i  (cm_v),
    .wa_i  (cm_a),
    .wbw_i (cm_bw),
    .wd_i  (data_i),
    .ra_i  (ra),
    .rd_o  (arr_d)
  );

  lw_sram_rdpath #(.AW(ADDR_W), .LANES(LANES), .BW(BYTE_W)) u_rdpath (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pipe_i  (pipe_mode_i),
    .rd_i    (op == OP_RD),
    .addr_i  (acc_a),
    .arr_i   (arr_d),
    .cm_v_i  (cm_v),
    .cm_a_i  (cm_a),
    .cm_bw_i (cm_bw),
    .wd_i    (data_i),
    .ra_o    (ra),
    .vld_o   (vld),
    .dat_o   (dat)
  );

  assign dq_oe_o = vld && !oe_ni && !sleep_i;
  assign data_o  = dq_oe_o ? dat : '0;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pipe_mode_i,
  input logic          sleep_i,
  input logic          oe_ni,
  input logic          ce1_ni,
  input logic          ce2_i,
  input logic          ce3_ni,
  input logic          adv_i,
  input logic          we_ni,
  input logic [DW-1:0] data_o,
  input logic          dq_oe_o
);
  logic sel, rd_load;
  assign sel     = !ce1_ni && ce2_i && !ce3_ni;
  assign rd_load = !adv_i && sel && we_ni && !sleep_i;

  p_desel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && !adv_i && !sel) |=> !dq_oe_o);

  p_pipe_desel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && !adv_i && !sel) |=> ##1 !dq_oe_o);

  p_flow_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && rd_load) |=> (dq_oe_o || oe_ni || sleep_i));

  p_pipe_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && rd_load) |=> ##1 (dq_oe_o || oe_ni || sleep_i));

  p_flow_wr_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && !adv_i && sel && !we_ni) |=> !dq_oe_o);

  p_oe_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!dq_oe_o && data_o == '0));

  p_sleep_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (!dq_oe_o && data_o == '0));

  p_sleep_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_mode_i && sleep_i) |=> !dq_oe_o);
endmodule

bind lw_burst_sram lw_sram_chk #(.DW(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pipe_mode_i (pipe_mode_i),
  .sleep_i     (sleep_i),
  .oe_ni       (oe_ni),
  .ce1_ni      (ce1_ni),
  .ce2_i       (ce2_i),
  .ce3_ni      (ce3_ni),
  .adv_i       (adv_i),
  .we_ni       (we_ni),
  .data_o      (data_o),
  .dq_oe_o     (dq_oe_o)
);

// File: tb/sim_lw_burst_sram.sv
module sim_lw_burst_sram;
  localparam int AW = 6;
  localparam int BW = 9;
  localparam int LN = 2;
  localparam int DW = LN * BW;
  localparam logic [2:0] CE_ON  = 3'b010;  // {ce1_ni, ce2_i, ce3_ni}
  localparam logic [2:0] CE_OFF = 3'b111;

  logic          clk_i = 1'b0, rst_ni = 1'b1;
  logic          pipe_mode_i = 1'b0, burst_ilv_i = 1'b0, sleep_i = 1'b0, oe_ni = 1'b0;
  logic          ce1_ni = 1'b1, ce2_i = 1'b0, ce3_ni = 1'b1, adv_i = 1'b0, we_ni = 1'b1;
  logic [LN-1:0] bw_ni = '1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          dq_oe_o;

  always #5 clk_i = ~clk_i;

  lw_burst_sram #(.ADDR_W(AW), .BYTE_W(BW), .LANES(LN)) u0 (
    .clk_i, .rst_ni, .pipe_mode_i, .burst_ilv_i, .sleep_i, .oe_ni,
    .ce1_ni, .ce2_i, .ce3_ni, .adv_i, .we_ni, .bw_ni, .addr_i, .data_i,
    .data_o, .dq_oe_o
  );

  int checks = 0, errors = 0, e = 0;
  bit done = 0;
  string cur_tag = "R12";

  logic [DW-1:0] mem_m [1<<AW];
  logic          wq_v [4];
  logic [AW-1:0] wq_a [4];
  logic [LN-1:0] wq_bw [4];
  logic          rq_v [4];
  logic [AW-1:0] rq_a [4];
  string         rq_tag [4];
  logic          exp_v;
  logic [DW-1:0] exp_d;
  string         exp_tag;
  logic          b_act, b_wr;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;

  function automatic logic [DW-1:0] gen(int k);
    logic [31:0] t;
    t = k * 32'd40503 + 32'd7717;
    return t[DW-1:0] ^ t[31:14];
  endfunction

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 4; i++) begin
      wq_v[i] = 1'b0;
      rq_v[i] = 1'b0;
    end
    b_act = 1'b0;
    exp_v = 1'b0;
  endtask

  task automatic step(input logic adv, input logic [2:0] ce, input logic we_n,
                      input logic [LN-1:0] bwn, input logic [AW-1:0] a,
                      input logic sl, input logic oe);
    logic          sel, acc, want;
    logic [AW-1:0] aa;
    logic [1:0]    lo;
    int            lag, s;
    adv_i = adv; {ce1_ni, ce2_i, ce3_ni} = ce; we_ni = we_n; bw_ni = bwn;
    addr_i = a; sleep_i = sl; oe_ni = oe; data_i = gen(e);
    @(posedge clk_i);
    lag = pipe_mode_i ? 2 : 1;
    s = e % 4;
    if (wq_v[s]) begin
      for (int l = 0; l < LN; l++)
        if (wq_bw[s][l]) mem_m[wq_a[s]][l*BW +: BW] = gen(e)[l*BW +: BW];
      wq_v[s] = 1'b0;
    end
    sel = !ce[2] && ce[1] && !ce[0];
    acc = 1'b0;
    aa  = a;
    if (sl) b_act = 1'b0;
    else if (!adv) begin
      if (sel) begin
        acc = 1'b1; b_act = 1'b1; b_base = a; b_cnt = 2'd0; b_wr = !we_n;
      end else b_act = 1'b0;
    end else if (b_act && b_cnt != 2'd3) begin
      b_cnt = b_cnt + 2'd1;
      lo = burst_ilv_i ? (b_base[1:0] ^ b_cnt) : 2'((int'(b_base[1:0]) + int'(b_cnt)) % 4);
      aa = {b_base[AW-1:2], lo};
      acc = 1'b1;
    end else b_act = 1'b0;
    if (acc) begin
      if (b_wr) begin
        wq_v[(e+lag)%4] = 1'b1; wq_a[(e+lag)%4] = aa; wq_bw[(e+lag)%4] = ~bwn;
      end else begin
        rq_v[(e+lag-1)%4] = 1'b1; rq_a[(e+lag-1)%4] = aa; rq_tag[(e+lag-1)%4] = cur_tag;
      end
    end
    exp_v = 1'b0;
    exp_tag = cur_tag;
    if (rq_v[s]) begin
      exp_v = 1'b1; exp_d = mem_m[rq_a[s]]; exp_tag = rq_tag[s]; rq_v[s] = 1'b0;
    end
    e++;
    @(negedge clk_i);
    want = exp_v && !oe && !sl;
    check(exp_tag, "dq_oe_o", DW'(dq_oe_o), DW'(want));
    check(exp_tag, "data_o", data_o, want ? exp_d : '0);
  endtask

  task automatic wr(input int a, input logic [LN-1:0] bwn);
    step(1'b0, CE_ON, 1'b0, bwn, AW'(a), 1'b0, 1'b0);
  endtask
  task automatic rd(input int a);
    step(1'b0, CE_ON, 1'b1, 2'b11, AW'(a), 1'b0, 1'b0);
  endtask
  task automatic adv(input logic [2:0] ce, input logic [LN-1:0] bwn);
    step(1'b1, ce, 1'b1, bwn, '0, 1'b0, 1'b0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, CE_OFF, 1'b1, 2'b11, '0, 1'b0, 1'b0);
  endtask

  task automatic do_reset(input logic pm);
    @(negedge clk_i);
    rst_ni = 1'b0;
    {ce1_ni, ce2_i, ce3_ni} = CE_OFF; adv_i = 1'b0; sleep_i = 1'b0; oe_ni = 1'b0;
    pipe_mode_i = pm;
    clear_model();
    repeat (2) @(negedge clk_i);
    check("R12", "dq_oe_o in reset", DW'(dq_oe_o), '0);
    check("R12", "data_o in reset", data_o, '0);
    rst_ni = 1'b1;
    cur_tag = "R12";
    idle(1);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    for (int pm = 0; pm < 2; pm++) begin
      do_reset(pm[0]);
      cur_tag = "R4";
      for (int a = 0; a < (1 << AW); a++) wr(a, 2'b00);
      idle(2);
      cur_tag = pm[0] ? "R3" : "R2";
      for (int a = 0; a < (1 << AW); a++) rd(a);
      idle(2);
      cur_tag = "R5";
      for (int a = 0; a < 8; a++) wr(a, LN'(a % 4));
      idle(2);
      for (int a = 0; a < 8; a++) rd(a);
      idle(2);
      cur_tag = "R6";
      for (int k = 0; k < 16; k++) begin
        rd(k); wr(k, 2'b00); rd(k); wr(k + 20, 2'b01); rd(k + 20); rd(k);
      end
      idle(3);
      for (int ilv = 0; ilv < 2; ilv++) begin
        for (int s = 0; s < 4; s++) begin
          cur_tag = ilv ? "R8" : "R7";
          burst_ilv_i = ilv[0];
          wr(40 + s, 2'b00);
          for (int b = 0; b < 3; b++) adv(CE_OFF, LN'(b));
          idle(2);
          for (int a = 40; a < 44; a++) rd(a);
          rd(40 + s);
          for (int b = 0; b < 3; b++) adv(CE_ON, 2'b11);
          idle(2);
        end
      end
      burst_ilv_i = 1'b0;
      cur_tag = "R9";
      rd(45);
      for (int b = 0; b < 5; b++) adv(CE_OFF, 2'b11);
      idle(2);
      adv(CE_ON, 2'b11);
      wr(50, 2'b00);
      for (int b = 0; b < 3; b++) adv(CE_OFF, 2'b00);
      adv(CE_ON, 2'b00);
      idle(2);
      for (int a = 48; a < 52; a++) rd(a);
      idle(2);
      cur_tag = "R1";
      for (int c = 0; c < 8; c++) begin
        step(1'b0, 3'(c), 1'b1, 2'b11, AW'(c + 1), 1'b0, 1'b0);
        idle(2);
      end
      cur_tag = "R10";
      for (int k = 0; k < 6; k++) step(1'b0, CE_ON, 1'b1, 2'b11, AW'(k), 1'b0, 1'(k % 2));
      for (int k = 0; k < 3; k++) step(1'b0, CE_OFF, 1'b1, 2'b11, '0, 1'b0, 1'(k % 2));
      cur_tag = "R11";
      wr(60, 2'b00);
      rd(61);
      step(1'b0, CE_ON, 1'b1, 2'b11, AW'(62), 1'b1, 1'b0);
      step(1'b0, CE_ON, 1'b0, 2'b00, AW'(63), 1'b1, 1'b0);
      step(1'b1, CE_ON, 1'b1, 2'b11, '0, 1'b1, 1'b0);
      idle(2);
      rd(60); rd(63);
      idle(3);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule